// File: doc/BRIEF.md
# Chroma 4:4:4 to 4:2:2 Decimator

This block takes one YCbCr pixel per clock on three parallel buses (luma, blue-difference, red-difference). In its half-rate chroma format it outputs luma on one bus and packs the two chroma components onto a single shared chroma bus. On each pair of pixels the chroma bus carries the blue-difference sample of the even pixel next to that pixel's luma, then the red-difference sample of the same even pixel next to the odd pixel's luma. The odd pixel's chroma is dropped, and no filtering is applied.

A rising edge on the sync strobe fixes where the pixel pairs start. The first pixel taken after the strobe is treated as even. In full format the three components pass through unchanged on three buses and the strobe has no effect. A synchronous enable input freezes every register in the block, so a stream can be paused and resumed with no sample lost or repeated.

Top module: `chroma_decim`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero after that edge, and `vld_out` is 0.
- R2: With `fmt_sel`=0 (full format), the Y, Cb and Cr of a pixel presented before enabled edge k appear on `y_out`, `cb_out` and `cc_out` after enabled edge k+1. `vld_out` is 1 from the second enabled edge after reset onward.
- R3: With `fmt_sel`=0, pulses on `sync` have no effect on any output.
- R4: With `fmt_sel`=1 (half format), take an edge at which `sync` is sampled high after being sampled low at the previous enabled edge. The pixel sampled at the next enabled edge becomes even pixel 0. Its Y appears on `y_out` one enabled edge later, with `vld_out`=1.
- R5: With `fmt_sel`=1, an even pixel's output has `cc_out` equal to that pixel's Cb. The following odd pixel's output has `cc_out` equal to the Cr of that even pixel. The odd pixel's Cb and Cr never appear.
- R6: With `fmt_sel`=1, `cb_out` is 0.
- R7: With `fmt_sel`=1, after reset `vld_out` stays 0 until a sync rising edge has been seen.
- R8: A new sync rising edge at any time makes the next sampled pixel even, whatever the current phase is.
- R9: If `oe` is sampled low at edge k, then edge k+1 changes no register, so all outputs hold. Operation continues at the edge after the first edge that samples `oe` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 1 | 0 = full format pass-through, 1 = half chroma format |
| oe | input | 1 | Synchronous enable, acting one edge late |
| sync | input | 1 | Pairing strobe; its rising edge sets the start phase |
| y_in | input | W | Luma input |
| cb_in | input | W | Blue-difference input |
| cr_in | input | W | Red-difference input |
| y_out | output | W | Luma output |
| cc_out | output | W | Shared chroma output in half format, Cr in full format |
| cb_out | output | W | Cb output in full format, zero in half format |
| vld_out | output | 1 | Output data valid |

## Verification
The bench restarts the pairing with a second strobe on an even pixel. A design that ignored the re-strobe, or re-armed it one edge off, would put Cr where Cb belongs for every later pair. It checks that `vld_out` stays low before any strobe, and that odd pixels carry the even pixel's Cr, never their own, so a design that forwarded rather than held chroma would fail. It pauses `oe` in the middle of a stream and compares against a model that honours the one-edge delay of the enable; a design that froze immediately, or lost or doubled a sample, would miss there. It also pulses `sync` in full format, to catch a design that lets the strobe disturb pass-through.

// File: rtl/cdec_pkg.sv
// Shared types for the chroma decimator.
// Assumes: a single output format bit chosen by the integrator.
package cdec_pkg;
    typedef enum logic {
        FMT_FULL = 1'b0,
        FMT_HALF = 1'b1
    } fmt_e;
endpackage

// File: rtl/cdec_gate.sv
// Enable delay stage: turns the synchronous output-enable into the run
// qualifier for every other register, one edge late, so that the edge
// after the one sampling oe is the first affected.
// Assumes: oe meets setup and hold to clk.
module cdec_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic oe,
    output logic run
);
    // Register the enable; the block holds during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= oe;
    end

    // R9
    gate_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> !run);
endmodule

// File: rtl/cdec_phase.sv
// Phase tracker: detects the sync rising edge and arms a restart. On the
// next enabled edge it marks the pixel being sampled as even, then
// toggles the phase. It also raises the live flag.
// Assumes: sync is only looked at on enabled edges; in full format the
// strobe is ignored and data is live immediately.
module cdec_phase
    import cdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  fmt_e fmt,
    input  logic sync,
    output logic phase,
    output logic live
);
    logic sync_q;
    logic arm;

    // Track sync edges, arm the restart, and step the pair phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            arm    <= 1'b0;
            phase  <= 1'b0;
            live   <= 1'b0;
        end else if (run) begin
            sync_q <= sync;
            if (fmt == FMT_HALF) begin
                arm <= sync & ~sync_q;
                if (arm) begin
                    phase <= 1'b0;
                    live  <= 1'b1;
                end else begin
                    phase <= ~phase;
                end
            end else begin
                arm  <= 1'b0;
                live <= 1'b1;
            end
        end
    end

    // R8
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fmt == FMT_HALF && !arm) |=> (phase != $past(phase)));

    // R7
    live_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(live) && $past(fmt) == FMT_HALF) |-> $past(arm));
endmodule

// File: rtl/cdec_mux.sv
// Output stage: in half format it sends Cb of the even pixel, then that
// pixel's held Cr, on the shared chroma bus and zeroes the Cb bus. In
// full format it forwards all three components.
// Assumes: phase 0 marks an even pixel in the input registers.
module cdec_mux
    import cdec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  fmt_e         fmt,
    input  logic         phase,
    input  logic         live,
    input  logic [W-1:0] y_r,
    input  logic [W-1:0] cb_r,
    input  logic [W-1:0] cr_r,
    output logic [W-1:0] y_out,
    output logic [W-1:0] cc_out,
    output logic [W-1:0] cb_out,
    output logic         vld_out
);
    logic [W-1:0] held_cr;

    // Select and register the output buses on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out   <= '0;
            cc_out  <= '0;
            cb_out  <= '0;
            vld_out <= 1'b0;
            held_cr <= '0;
        end else if (run) begin
            y_out   <= y_r;
            vld_out <= live;
            if (fmt == FMT_HALF) begin
                cb_out <= '0;
                if (!phase) begin
                    cc_out  <= cb_r;
                    held_cr <= cr_r;
                end else begin
                    cc_out  <= held_cr;
                end
            end else begin
                cc_out <= cr_r;
                cb_out <= cb_r;
            end
        end
    end

    // R5
    even_cb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fmt == FMT_HALF && !phase) |=> (cc_out == $past(cb_r)));

    // R6
    cb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fmt == FMT_HALF) |=> (cb_out == '0));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(y_out) && $stable(cc_out) && $stable(vld_out)));
endmodule

// File: rtl/chroma_decim.sv
// Top of the chroma decimator: input sampling registers, enable delay,
// phase tracker and output multiplexer.
// Assumes: one pixel per clock, all inputs synchronous to clk.
module chroma_decim
    import cdec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fmt_sel,
    input  logic         oe,
    input  logic         sync,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] cb_in,
    input  logic [W-1:0] cr_in,
    output logic [W-1:0] y_out,
    output logic [W-1:0] cc_out,
    output logic [W-1:0] cb_out,
    output logic         vld_out
);
    fmt_e         fmt;
    logic         run;
    logic         phase;
    logic         live;
    logic [W-1:0] y_r;
    logic [W-1:0] cb_r;
    logic [W-1:0] cr_r;

    assign fmt = fmt_e'(fmt_sel);

    cdec_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .oe    (oe),
        .run   (run)
    );

    // Sample the incoming pixel on every enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_r  <= '0;
            cb_r <= '0;
            cr_r <= '0;
        end else if (run) begin
            y_r  <= y_in;
            cb_r <= cb_in;
            cr_r <= cr_in;
        end
    end

    cdec_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .fmt   (fmt),
        .sync  (sync),
        .phase (phase),
        .live  (live)
    );

    cdec_mux #(.W(W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .fmt     (fmt),
        .phase   (phase),
        .live    (live),
        .y_r     (y_r),
        .cb_r    (cb_r),
        .cr_r    (cr_r),
        .y_out   (y_out),
        .cc_out  (cc_out),
        .cb_out  (cb_out),
        .vld_out (vld_out)
    );

    // R9
    in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(y_r) && $stable(cb_r) && $stable(cr_r)));
endmodule

// File: tb/sim_chroma_decim.sv
// Directed bench for the chroma decimator; one task per scenario.
module sim_chroma_decim;
    localparam int CLK_NS = 10;
    localparam int W      = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fmt_sel = 1'b0;
    logic         oe = 1'b1;
    logic         sync = 1'b0;
    logic [W-1:0] y_in = '0;
    logic [W-1:0] cb_in = '0;
    logic [W-1:0] cr_in = '0;
    logic [W-1:0] y_out;
    logic [W-1:0] cc_out;
    logic [W-1:0] cb_out;
    logic         vld_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    chroma_decim #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .oe(oe), .sync(sync),
        .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .y_out(y_out), .cc_out(cc_out), .cb_out(cb_out), .vld_out(vld_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [W-1:0] py(int j);  return W'(8'h10 + j); endfunction
    function automatic logic [W-1:0] pcb(int j); return W'(8'h40 + j); endfunction
    function automatic logic [W-1:0] pcr(int j); return W'(8'h90 + j); endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(int j);
        y_in = py(j); cb_in = pcb(j); cr_in = pcr(j);
    endtask

    // Reset state.
    task automatic t_reset();
        rst_n = 1'b0; fmt_sel = 1'b1; oe = 1'b1; sync = 1'b0; put(7);
        repeat (3) @(negedge clk);
        chk("R1 y_out", y_out, 0);
        chk("R1 cc_out", cc_out, 0);
        chk("R1 cb_out", cb_out, 0);
        chk("R1 vld_out", vld_out, 0);
        rst_n = 1'b1;
    endtask

    // Half format, no strobe yet: valid must stay low.
    task automatic t_prestrobe();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            put(i + 50);
            chk("R7 vld before strobe", vld_out, 0);
        end
    endtask

    // Half format stream; optional re-strobe on pixel m.
    task automatic t_stream(bit restrobe, int m);
        int n = 12;
        bit ph [0:15];
        for (int j = 0; j < n; j++)
            ph[j] = (j == 0) ? 1'b0 : ((restrobe && j == m + 1) ? 1'b0 : ~ph[j-1]);
        fmt_sel = 1'b1;
        @(negedge clk); sync = 1'b0; put(99);
        @(negedge clk); sync = 1'b0;
        @(negedge clk); sync = 1'b1; put(98);
        for (int k = 0; k < n + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                int j = k - 2;
                chk(restrobe ? "R8 y" : "R4 y", y_out, py(j));
                chk(restrobe ? "R8 vld" : "R4 vld", vld_out, 1);
                chk(restrobe ? "R8 chroma" : "R5 chroma", cc_out,
                    ph[j] ? pcr(j - 1) : pcb(j));
                chk("R6 cb_out", cb_out, 0);
            end
            sync = (restrobe && k == m) ? 1'b1 : 1'b0;
            if (k < n) put(k); else put(97);
        end
        sync = 1'b0;
    endtask

    // Full format with an enable pause and a sync pulse.
    task automatic t_pass_enable();
        logic [W-1:0] ay, acb, acr, oy, ocb, ocr;
        bit prev_oe = 1'b1;
        int act = 0;
        ay = '0; acb = '0; acr = '0; oy = '0; ocb = '0; ocr = '0;
        fmt_sel = 1'b0; oe = 1'b1; sync = 1'b0;
        for (int i = 0; i < 30; i++) begin
            bit oe_i;
            @(negedge clk);
            if (act >= 2) begin
                chk((i > 15) ? "R3 y" : "R2/R9 y", y_out, oy);
                chk((i > 15) ? "R3 cb" : "R2/R9 cb", cb_out, ocb);
                chk((i > 15) ? "R3 cr" : "R2/R9 cr", cc_out, ocr);
                chk("R2 vld", vld_out, 1);
            end
            oe_i = !(i >= 6 && i <= 9);
            oe = oe_i;
            sync = (i == 17 || i == 18 || i == 22) ? 1'b1 : 1'b0;
            put(i + 100);
            if (prev_oe) begin
                oy = ay; ocb = acb; ocr = acr;
                ay = py(i + 100); acb = pcb(i + 100); acr = pcr(i + 100);
                act++;
            end
            prev_oe = oe_i;
        end
        oe = 1'b1; sync = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 20000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        t_reset();
        t_prestrobe();
        t_stream(1'b0, 0);
        t_stream(1'b1, 4);
        t_pass_enable();
        finish_up();
    end
endmodule